// File: doc/BRIEF.md
# Clock-Tolerance Rate Match FIFO

This block joins a receive path clocked by a recovered clock to a core path clocked by a local clock of nearly the same frequency. Ten-bit symbols enter on the write clock and leave on the read clock through a sixteen-entry buffer. The two clocks drift apart slowly, so the block keeps the buffer from running dry or spilling over. It drops an incoming skip symbol when the buffer is nearly full. It repeats an outgoing skip symbol when the buffer is nearly empty. Each action raises a one-cycle status pulse, as do overflow and underflow.

Skip symbols are recognised by comparison with two programmable codes, and a configuration bit can limit recognition to the first code. The fill limits for dropping and repeating are programmable. A further option requires a non-skip symbol between two successive drops, and likewise between two successive repeats. Another option makes the block emit a programmable pad symbol when a read finds the buffer empty. A mode input can switch rate matching off entirely, and the block then acts as a plain dual-clock FIFO.

Top module: `rate_match_fifo`

## Requirements
- R1: While either reset is low, rdValid, rdData, insertPulse, underflow, deletePulse and overflow are all 0.
- R2: Written symbols reach rdData in write order, with rdValid high one read clock after the rdEn edge that takes them. A symbol stored at a write edge can first be taken at the third read edge after it. Write-side fill is the write pointer minus the read pointer value from three write edges earlier.
- R3: A symbol counts as a skip when it equals cfgSkipA, or when it equals cfgSkipB and cfgSkipAOnly is 0.
- R4: When cfgMode is not 0, and wrValid carries a skip while the write-side fill is at or above cfgFullThr, the symbol is not stored and deletePulse is high for the next write clock.
- R5: When cfgMode is not 0, and rdEn finds a skip at the head while the read-side fill is nonzero and at or below cfgEmptyThr, the skip is output but not consumed, and insertPulse is high for the next read clock.
- R6: With cfgBackToBack at 0, a second deletion (or insertion) is refused until a non-skip symbol has been stored (or consumed) after the previous one.
- R7: A write that is neither deleted nor accepted, because the write-side fill equals 16, is dropped and overflow pulses for one write clock. A deletion takes precedence over an overflow.
- R8: rdEn with a read-side fill of 0 pulses underflow. When cfgMode is not 0 and cfgPadEn is 1, the same read outputs cfgPadSym with rdValid high. Otherwise rdValid stays low.
- R9: cfgMode encodes 0 = off, 1 = single width, 2 = double width and 3 = spare. Every nonzero code applies the rules of R4 to R8. Code 0 never deletes, inserts or pads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Recovered receive clock |
| wrRstN | input | 1 | Active-low asynchronous reset, write side |
| wrValid | input | 1 | Symbol present on wrData |
| wrData | input | 10 | Incoming symbol |
| rdClk | input | 1 | Local core clock |
| rdRstN | input | 1 | Active-low asynchronous reset, read side |
| rdEn | input | 1 | Request one symbol |
| rdValid | output | 1 | rdData holds a delivered symbol |
| rdData | output | 10 | Outgoing symbol |
| cfgMode | input | 2 | Rate-match mode (R9) |
| cfgSkipA | input | 10 | First skip code |
| cfgSkipB | input | 10 | Second skip code |
| cfgSkipAOnly | input | 1 | Recognise only cfgSkipA |
| cfgFullThr | input | 4 | Almost-full fill limit |
| cfgEmptyThr | input | 4 | Almost-empty fill limit |
| cfgBackToBack | input | 1 | Allow consecutive deletions or insertions |
| cfgPadEn | input | 1 | Emit pad symbol on underflow |
| cfgPadSym | input | 10 | Pad symbol |
| deletePulse | output | 1 | A skip was dropped (write clock) |
| overflow | output | 1 | A symbol was lost on a full buffer (write clock) |
| insertPulse | output | 1 | A skip was repeated (read clock) |
| underflow | output | 1 | A read found the buffer empty (read clock) |

## Verification
Every status pulse and every delivered symbol is registered, so each appears one clock after the edge that made the decision. Because each pointer passes a register and two synchroniser stages, each side sees the other's pointer three edges late. The bench runs both clocks from one source so that this lag is exact. Its model keeps a per-edge history of both pointers and reads the entry three edges back when it computes fill. Inputs change at the falling edge, the model is stepped there for the coming rising edge, and the outputs are compared at the next falling edge, half a cycle after the registers settle.

// File: rtl/rm_pkg.sv
package rm_pkg;

  typedef enum logic [1:0] {
    RM_OFF    = 2'd0,
    RM_SINGLE = 2'd1,
    RM_DOUBLE = 2'd2,
    RM_SPARE  = 2'd3
  } rmMode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic wrStore;  // write clock: store wrData at wrAddr
    logic rdTake;   // read clock: load head symbol into rdData
    logic rdPad;    // read clock: load pad symbol into rdData
  } rmStrb_t;

endpackage

// File: rtl/rm_sync.sv
module rm_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/rm_ctrl.sv
module rm_ctrl
  import rm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrValid,
  input  logic              wrIsSkip,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdEn,
  input  logic              headIsSkip,
  input  logic              rmOn,
  input  logic [ADDR_W-1:0] fullThr,
  input  logic [ADDR_W-1:0] emptyThr,
  input  logic              allowB2B,
  input  logic              padOn,
  output rmStrb_t           strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdValid,
  output logic              insertPulse,
  output logic              underflow,
  output logic              deletePulse,
  output logic              overflow
);
  localparam int PW = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

  logic [PW-1:0] wrPtr, wrGray, wrGraySync, wrPtrSeen, wrFill, wrPtrNext;
  logic [PW-1:0] rdPtr, rdGray, rdGraySync, rdPtrSeen, rdFill, rdPtrNext;
  logic          wrLastDel, rdLastIns;
  logic          doDel, doOvf, doStore;
  logic          doUnd, doIns, doTake, doAdv, doPad, rdEmpty;

  rm_sync #(.W(PW)) uRd2Wr (.clk(wrClk), .rstN(wrRstN), .d(rdGray), .q(rdGraySync));
  rm_sync #(.W(PW)) uWr2Rd (.clk(rdClk), .rstN(rdRstN), .d(wrGray), .q(wrGraySync));

  always_comb begin
    for (int i = 0; i < PW; i++) begin
      rdPtrSeen[i] = ^(rdGraySync >> i);
      wrPtrSeen[i] = ^(wrGraySync >> i);
    end
  end

  // ---------------- write side ----------------
  assign wrFill  = wrPtr - rdPtrSeen;
  assign doDel   = wrValid && rmOn && wrIsSkip && (wrFill >= {1'b0, fullThr})
                   && (allowB2B || !wrLastDel);
  assign doOvf   = wrValid && !doDel && (wrFill == FULL_CNT);
  assign doStore = wrValid && !doDel && !doOvf;
  assign wrPtrNext = wrPtr + PW'(doStore);

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrPtr       <= '0;
      wrGray      <= '0;
      wrLastDel   <= 1'b0;
      deletePulse <= 1'b0;
      overflow    <= 1'b0;
    end else begin
      wrPtr       <= wrPtrNext;
      wrGray      <= wrPtrNext ^ (wrPtrNext >> 1);
      deletePulse <= doDel;
      overflow    <= doOvf;
      if (doDel)                      wrLastDel <= 1'b1;
      else if (doStore && !wrIsSkip)  wrLastDel <= 1'b0;
    end
  end

  // ---------------- read side ----------------
  assign rdFill  = wrPtrSeen - rdPtr;
  assign rdEmpty = (rdFill == '0);
  assign doUnd   = rdEn && rdEmpty;
  assign doPad   = doUnd && rmOn && padOn;
  assign doTake  = rdEn && !rdEmpty;
  assign doIns   = doTake && rmOn && headIsSkip && (rdFill <= {1'b0, emptyThr})
                   && (allowB2B || !rdLastIns);
  assign doAdv   = doTake && !doIns;
  assign rdPtrNext = rdPtr + PW'(doAdv);

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdPtr       <= '0;
      rdGray      <= '0;
      rdLastIns   <= 1'b0;
      rdValid     <= 1'b0;
      insertPulse <= 1'b0;
      underflow   <= 1'b0;
    end else begin
      rdPtr       <= rdPtrNext;
      rdGray      <= rdPtrNext ^ (rdPtrNext >> 1);
      rdValid     <= doTake || doPad;
      insertPulse <= doIns;
      underflow   <= doUnd;
      if (doIns)                      rdLastIns <= 1'b1;
      else if (doAdv && !headIsSkip)  rdLastIns <= 1'b0;
    end
  end

  always_comb begin
    strb.wrStore = doStore;
    strb.rdTake  = doTake;
    strb.rdPad   = doPad;
  end

  assign wrAddr = wrPtr[ADDR_W-1:0];
  assign rdAddr = rdPtr[ADDR_W-1:0];

  // ---------------- assertions ----------------
  a_r7_fill_bound: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrFill <= FULL_CNT);
  a_r7_delete_beats_overflow: assert property (@(posedge wrClk) disable iff (!wrRstN)
    !(deletePulse && overflow));
  a_r9_off_no_delete: assert property (@(posedge wrClk) disable iff (!wrRstN)
    !rmOn |=> !deletePulse);
  a_r6_no_b2b_delete: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (!allowB2B && deletePulse) |=> (!deletePulse || $past(allowB2B)));
  a_r5_insert_holds_ptr: assert property (@(posedge rdClk) disable iff (!rdRstN)
    insertPulse |-> $stable(rdPtr));
  a_r6_no_b2b_insert: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (!allowB2B && insertPulse) |=> (!insertPulse || $past(allowB2B)));
  a_r9_off_no_insert: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !rmOn |=> !insertPulse);
  a_r8_underflow_valid: assert property (@(posedge rdClk) disable iff (!rdRstN)
    underflow |-> (rdValid == $past(padOn && rmOn)));

endmodule

// File: rtl/rm_dpath.sv
module rm_dpath
  import rm_pkg::*;
#(
  parameter int SYM_W  = 10,
  parameter int ADDR_W = 4
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic [SYM_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  rmStrb_t           strb,
  input  logic [SYM_W-1:0]  skipA,
  input  logic [SYM_W-1:0]  skipB,
  input  logic              skipAOnly,
  input  logic [SYM_W-1:0]  padSym,
  output logic              wrIsSkip,
  output logic              headIsSkip,
  output logic [SYM_W-1:0]  rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [SYM_W-1:0] mem [DEPTH];
  logic [SYM_W-1:0] headSym;
  logic [SYM_W-1:0] probe [2];
  logic [1:0]       probeHit;

  always_ff @(posedge wrClk) begin
    if (strb.wrStore) mem[wrAddr] <= wrData;
  end

  assign headSym  = mem[rdAddr];
  assign probe[0] = wrData;
  assign probe[1] = headSym;

  for (genvar g = 0; g < 2; g++) begin : gMatch
    assign probeHit[g] = (probe[g] == skipA) || (!skipAOnly && (probe[g] == skipB));
  end

  assign wrIsSkip   = probeHit[0];
  assign headIsSkip = probeHit[1];

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN)          rdData <= '0;
    else if (strb.rdTake) rdData <= headSym;
    else if (strb.rdPad)  rdData <= padSym;
  end

  a_r8_pad_value: assert property (@(posedge rdClk) disable iff (!rdRstN)
    strb.rdPad |=> (rdData == $past(padSym)));
  a_r2_take_pad_exclusive: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !(strb.rdTake && strb.rdPad));

endmodule

// File: rtl/rate_match_fifo.sv
module rate_match_fifo
  import rm_pkg::*;
#(
  parameter int SYM_W  = 10,
  parameter int ADDR_W = 4
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrValid,
  input  logic [SYM_W-1:0]  wrData,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdEn,
  output logic              rdValid,
  output logic [SYM_W-1:0]  rdData,
  input  logic [1:0]        cfgMode,
  input  logic [SYM_W-1:0]  cfgSkipA,
  input  logic [SYM_W-1:0]  cfgSkipB,
  input  logic              cfgSkipAOnly,
  input  logic [ADDR_W-1:0] cfgFullThr,
  input  logic [ADDR_W-1:0] cfgEmptyThr,
  input  logic              cfgBackToBack,
  input  logic              cfgPadEn,
  input  logic [SYM_W-1:0]  cfgPadSym,
  output logic              deletePulse,
  output logic              overflow,
  output logic              insertPulse,
  output logic              underflow
);
  rmMode_e           modeSel;
  logic              rmOn;
  rmStrb_t           strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic              wrIsSkip, headIsSkip;

  assign modeSel = rmMode_e'(cfgMode);
  assign rmOn    = (modeSel != RM_OFF);

  rm_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrValid(wrValid), .wrIsSkip(wrIsSkip),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn), .headIsSkip(headIsSkip),
    .rmOn(rmOn), .fullThr(cfgFullThr), .emptyThr(cfgEmptyThr),
    .allowB2B(cfgBackToBack), .padOn(cfgPadEn),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .rdValid(rdValid), .insertPulse(insertPulse), .underflow(underflow),
    .deletePulse(deletePulse), .overflow(overflow)
  );

  rm_dpath #(.SYM_W(SYM_W), .ADDR_W(ADDR_W)) uDpath (
    .wrClk(wrClk), .rdClk(rdClk), .rdRstN(rdRstN),
    .wrData(wrData), .wrAddr(wrAddr), .rdAddr(rdAddr), .strb(strb),
    .skipA(cfgSkipA), .skipB(cfgSkipB), .skipAOnly(cfgSkipAOnly),
    .padSym(cfgPadSym), .wrIsSkip(wrIsSkip), .headIsSkip(headIsSkip),
    .rdData(rdData)
  );
endmodule

// File: tb/rate_match_fifo_bench.sv
`timescale 1ns/1ps
module rate_match_fifo_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rstN, wrValid, rdEn;
  logic [9:0] wrData, skA, skB, padS;
  logic [1:0] cfgMode;
  logic       only1, b2b, padEn;
  logic [3:0] afT, aeT;
  logic       rdValid, deletePulse, overflow, insertPulse, underflow;
  logic [9:0] rdData;

  rate_match_fifo u_rate_match_fifo (
    .wrClk(clk), .wrRstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .rdClk(clk), .rdRstN(rstN), .rdEn(rdEn), .rdValid(rdValid), .rdData(rdData),
    .cfgMode(cfgMode), .cfgSkipA(skA), .cfgSkipB(skB), .cfgSkipAOnly(only1),
    .cfgFullThr(afT), .cfgEmptyThr(aeT), .cfgBackToBack(b2b),
    .cfgPadEn(padEn), .cfgPadSym(padS),
    .deletePulse(deletePulse), .overflow(overflow),
    .insertPulse(insertPulse), .underflow(underflow)
  );

  int checks = 0, fails = 0;
  string tag = "R1";

  // Behavioural reference model
  logic [9:0] mm [16];
  int wP = 0, rP = 0;
  int wH[$], rH[$];
  bit lastDel = 0, lastIns = 0;
  bit eVld = 0, eIns = 0, eUnd = 0, eDel = 0, eOvf = 0;
  logic [9:0] eData = '0;

  function automatic bit mSkip(logic [9:0] s);
    return (s == skA) || (!only1 && (s == skB));
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (phase %s) %s actual=%0h expected=%0h", req, tag, what, act, exp);
    end
  endtask

  task automatic modelStep(bit wv, logic [9:0] wd, bit re);
    int n, rSeen, wSeen, wf, rf;
    bit on;
    logic [9:0] head;
    n = wH.size();
    rSeen = (n >= 3) ? rH[n-3] : 0;
    wSeen = (n >= 3) ? wH[n-3] : 0;
    on = (cfgMode != 2'd0);
    wf = wP - rSeen;
    rf = wSeen - rP;
    eVld = 0; eIns = 0; eUnd = 0; eDel = 0; eOvf = 0;
    if (re) begin
      if (rf == 0) begin
        eUnd = 1;
        if (on && padEn) begin eVld = 1; eData = padS; end
      end else begin
        head = mm[rP % 16];
        eVld = 1; eData = head;
        if (on && mSkip(head) && rf <= int'(aeT) && (b2b || !lastIns)) begin
          eIns = 1; lastIns = 1;
        end else begin
          rP++;
          if (!mSkip(head)) lastIns = 0;
        end
      end
    end
    if (wv) begin
      if (on && mSkip(wd) && wf >= int'(afT) && (b2b || !lastDel)) begin
        eDel = 1; lastDel = 1;
      end else if (wf == 16) begin
        eOvf = 1;
      end else begin
        mm[wP % 16] = wd;
        wP++;
        if (!mSkip(wd)) lastDel = 0;
      end
    end
    wH.push_back(wP);
    rH.push_back(rP);
  endtask

  task automatic compareAll();
    chk("R2", "rdValid", int'(rdValid), int'(eVld));
    if (eVld) chk("R2", "rdData", int'(rdData), int'(eData));
    chk("R5", "insertPulse", int'(insertPulse), int'(eIns));
    chk("R8", "underflow", int'(underflow), int'(eUnd));
    chk("R4", "deletePulse", int'(deletePulse), int'(eDel));
    chk("R7", "overflow", int'(overflow), int'(eOvf));
  endtask

  // Called at a falling edge: drive, predict, wait one cycle, compare.
  task automatic cyc(bit wv, logic [9:0] wd, bit re);
    wrValid = wv; wrData = wd; rdEn = re;
    modelStep(wv, wd, re);
    @(negedge clk);
    compareAll();
  endtask

  function automatic logic [9:0] pick(int skipPct);
    logic [9:0] d;
    if (int'($urandom % 100) < skipPct) return ($urandom % 2) ? skA : skB;
    d = 10'($urandom);
    while (d == skA || d == skB) d = d + 10'd1;
    return d;
  endfunction

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL R2 (phase %s) watchdog expired actual=0 expected=1", tag);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 0; wrValid = 0; wrData = '0; rdEn = 0;
    cfgMode = 2'd1; skA = 10'h0F9; skB = 10'h306; padS = 10'h2AA;
    only1 = 0; b2b = 1; padEn = 0; afT = 4'd15; aeT = 4'd0;
    repeat (4) @(negedge clk);
    wrValid = 1; rdEn = 1; wrData = skA;
    @(negedge clk);
    // R1: outputs held at zero in reset
    chk("R1", "rdValid", int'(rdValid), 0);
    chk("R1", "rdData", int'(rdData), 0);
    chk("R1", "insertPulse", int'(insertPulse), 0);
    chk("R1", "underflow", int'(underflow), 0);
    chk("R1", "deletePulse", int'(deletePulse), 0);
    chk("R1", "overflow", int'(overflow), 0);
    wrValid = 0; rdEn = 0;
    rstN = 1;

    // R2: plain ordered transfer, no skips, limits out of reach
    tag = "R2";
    for (int i = 0; i < 200; i++) cyc($urandom % 2, pick(0), $urandom % 2);

    // R4 / R7: fill with skips from both codes, no reads
    tag = "R4";
    afT = 4'd4;
    for (int i = 0; i < 40; i++) cyc(1, (i % 3 == 0) ? ((i % 2) ? skB : skA) : pick(0), 0);
    for (int i = 0; i < 30; i++) cyc(0, '0, 1);

    // R6: no back-to-back deletions
    tag = "R6";
    b2b = 0; afT = 4'd2;
    for (int i = 0; i < 16; i++) cyc(1, (i % 4 == 3) ? pick(0) : skA, 0);
    for (int i = 0; i < 25; i++) cyc(0, '0, 1);

    // R3: second code ignored when restricted to the first
    tag = "R3";
    b2b = 1; afT = 4'd0; only1 = 1;
    for (int i = 0; i < 20; i++) cyc(1, (i % 2) ? skA : skB, 0);
    for (int i = 0; i < 25; i++) cyc(0, '0, 1);
    only1 = 0;

    // R5: insertion near empty
    tag = "R5";
    afT = 4'd15; aeT = 4'd8;
    for (int i = 0; i < 80; i++) cyc(($urandom % 10) < 6, pick(30), 1);

    // R6: no back-to-back insertions
    tag = "R6";
    b2b = 0;
    for (int i = 0; i < 80; i++) cyc(($urandom % 10) < 6, pick(40), 1);

    // R8: pad on underflow, then no pad
    tag = "R8";
    padEn = 1;
    for (int i = 0; i < 30; i++) cyc(0, '0, 1);
    padEn = 0;
    for (int i = 0; i < 10; i++) cyc(0, '0, 1);

    // R9: mode off ignores all rate-match options; code 2 acts as on
    tag = "R9";
    cfgMode = 2'd0; afT = 4'd0; aeT = 4'd15; padEn = 1; b2b = 1;
    for (int i = 0; i < 80; i++) cyc($urandom % 2, pick(50), $urandom % 2);
    cfgMode = 2'd2;
    for (int i = 0; i < 80; i++) cyc($urandom % 2, pick(50), $urandom % 2);

    // Mixed traffic across every option
    tag = "R2";
    cfgMode = 2'd1; afT = 4'd6; aeT = 4'd5; padEn = 0;
    for (int i = 0; i < 300; i++) begin
      if (i % 50 == 0) b2b = $urandom % 2;
      cyc(($urandom % 10) < 6, pick(25), ($urandom % 10) < 6);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule